// File: doc/BRIEF.md
# Dual-Mode Tiled Integer Matrix Multiply Engine

This block computes C = A × B on signed 8-bit operands. A is the M×K activation matrix and B is the K×N weight matrix. Each result is a signed 32-bit sum. Fully-connected and convolution layers both arrive in the same flat two-dimensional form, and the engine treats them the same way.

Before a layer starts, software fills two local operand stores through single-element write ports. The A store is addressed by row and k. The B store is addressed by column and k, so B is held transposed. Inside each store, element k of a row sits in bank k mod LANES, at word row·ceil(MAX_K/LANES) + k/LANES. That layout lets every core pull a LANES-wide slice of the reduction dimension in a single cycle.

A start pulse captures M, K, N and the dataflow mode. A scheduler then visits output tiles one at a time and finishes the whole K reduction of a tile before moving on. Three vector cores each perform a LANES-wide multiply-accumulate per cycle:
- **Input-broadcast (mode 0):** one A row feeds all three cores, and each core owns a different column. The tile is 1 row × 3 columns.
- **Weight-broadcast (mode 1):** one B column feeds all three cores, and each core owns a different row. The tile is 3 rows × 1 column.

Finished tiles are drained over a valid/ready port, one element per beat, tagged with its row and column.

The controller has four states:
- **IDLE:** waiting. IDLE→MAC on start.
- **MAC:** accumulating. MAC→MAC while K slices remain; MAC→EMIT on the last slice.
- **EMIT:** draining the tile. EMIT→EMIT while further lanes of the tile lie inside the matrix; EMIT→STEP when the final lane of the tile is accepted.
- **STEP:** advancing to the next tile. STEP→MAC if more tiles remain; STEP→IDLE with done after the final tile.

Top module: `gemm_engine`

## Requirements
- R1: After reset, out_valid, busy and done are all low.
- R2: cfg_m, cfg_k, cfg_n and cfg_mode are captured only when cfg_start is high in IDLE. Any change on the cfg inputs, including further start pulses, while busy is high has no effect on the results.
- R3: Every emitted out_data equals the exact signed sum over k < K of A[row][k]·B[k][col]. Operands are two's-complement 8-bit and the sum is 32-bit two's complement.
- R4: With cfg_mode = 0 (input-broadcast), tiles cover columns c..c+2 of one row. Tiles are visited row by row, with columns ascending within a row. Within a tile, elements are emitted by ascending column.
- R5: With cfg_mode = 1 (weight-broadcast), tiles cover rows r..r+2 of one column. Tiles are visited with r stepping by 3 in the outer loop and the column ascending in the inner loop. Within a tile, elements are emitted by ascending row.
- R6: Store contents at k ≥ K do not influence any result.
- R7: Lanes of an edge tile that fall at row ≥ M or column ≥ N are never emitted, so exactly M·N results leave per layer.
- R8: The first result of a layer becomes valid exactly ceil(K/4)+1 cycles after the cycle in which cfg_start is sampled.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_row and out_col hold their values.
- R10: done is high for exactly one cycle, in the cycle right after the last result is accepted. busy is low from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start a layer (used only in IDLE) |
| cfg_mode | input | 1 | 0 = input-broadcast, 1 = weight-broadcast |
| cfg_m | input | 12 | Rows of A, 1..MAX_M |
| cfg_k | input | 12 | Reduction length, 1..MAX_K |
| cfg_n | input | 12 | Columns of B, 1..MAX_N |
| a_we | input | 1 | Write strobe for the A store |
| a_row | input | 12 | A row index |
| a_k | input | 12 | A reduction index |
| a_wdata | input | 8 | A element (signed) |
| b_we | input | 1 | Write strobe for the B store |
| b_col | input | 12 | B column index |
| b_k | input | 12 | B reduction index |
| b_wdata | input | 8 | B element (signed) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32 | Signed accumulated result |
| out_row | output | 12 | Row of the result |
| out_col | output | 12 | Column of the result |
| busy | output | 1 | Layer in progress |
| done | output | 1 | One-cycle end-of-layer pulse |

## Verification
The checker watches four things on every cycle:
- the captured mode stays fixed while a layer runs;
- a stalled result holds its value and tags;
- every emitted row and column lies inside the captured dimensions;
- done lasts one cycle, shows no result beside it, and returns the engine to idle.

Some behaviour only the bench scenarios can show:
- numeric correctness against the bench's own product;
- the two tile orderings;
- masking of stale store data beyond K and of edge lanes;
- the first-result latency;
- immunity to config changes while busy.

The bench covers ragged and full-size shapes, 1×1×1, extreme operand values and random backpressure.

// File: rtl/gemm_pkg.sv
`timescale 1ns/1ps
package gemm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_EMIT,
        ST_STEP
    } gstate_t;

    typedef enum logic {
        MODE_IB = 1'b0,
        MODE_WB = 1'b1
    } gmode_t;
endpackage

// File: rtl/gemm_opbuf.sv
`timescale 1ns/1ps
// Banked operand store: element k of a row lives in bank k mod LANES.
module gemm_opbuf #(
    parameter int ROWS  = 12,
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    parameter int PORTS = 3,
    parameter int DIM_W = 12
) (
    input  logic                                clk,
    input  logic                                wr_en,
    input  logic [DIM_W-1:0]                    wr_row,
    input  logic [DIM_W-1:0]                    wr_k,
    input  logic [7:0]                          wr_data,
    input  logic [PORTS-1:0][DIM_W-1:0]         rd_row,
    input  logic [DIM_W-1:0]                    rd_kq,
    output logic [PORTS-1:0][LANES-1:0][7:0]    rd_vec
);
    localparam int LB    = $clog2(LANES);
    localparam int KQ    = (DEPTH + LANES - 1) / LANES;
    localparam int WORDS = ROWS * KQ;
    localparam int AW    = $clog2(WORDS);

    logic [7:0] bank_mem [LANES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en && wr_row < DIM_W'(ROWS) && wr_k < DIM_W'(DEPTH)) begin
            bank_mem[wr_k[LB-1:0]][AW'(wr_row * DIM_W'(KQ) + (wr_k >> LB))] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic in_range;
        assign in_range = (rd_row[p] < DIM_W'(ROWS)) && (rd_kq < DIM_W'(KQ));
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign rd_vec[p][l] = in_range ?
                bank_mem[l][AW'(rd_row[p] * DIM_W'(KQ) + rd_kq)] : 8'd0;
        end
    end
endmodule

// File: rtl/gemm_vcore.sv
`timescale 1ns/1ps
// One vector core: LANES signed 8x8 products summed into a 32-bit accumulator.
module gemm_vcore #(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic [LANES-1:0][7:0]      a_vec,
    input  logic [LANES-1:0][7:0]      b_vec,
    input  logic [LANES-1:0]           k_mask,
    output logic [31:0]                acc
);
    logic signed [31:0] dot;

    always_comb begin
        dot = '0;
        for (int l = 0; l < LANES; l++) begin
            if (k_mask[l]) begin
                dot = dot + 32'($signed(a_vec[l]) * $signed(b_vec[l]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + dot;
        end
    end
endmodule

// File: rtl/gemm_engine.sv
`timescale 1ns/1ps
module gemm_engine
    import gemm_pkg::*;
#(
    parameter int DIM_W = 12,
    parameter int LANES = 4,
    parameter int CORES = 3,
    parameter int MAX_M = 12,
    parameter int MAX_K = 16,
    parameter int MAX_N = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             cfg_mode,
    input  logic [DIM_W-1:0] cfg_m,
    input  logic [DIM_W-1:0] cfg_k,
    input  logic [DIM_W-1:0] cfg_n,
    input  logic             a_we,
    input  logic [DIM_W-1:0] a_row,
    input  logic [DIM_W-1:0] a_k,
    input  logic [7:0]       a_wdata,
    input  logic             b_we,
    input  logic [DIM_W-1:0] b_col,
    input  logic [DIM_W-1:0] b_k,
    input  logic [7:0]       b_wdata,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic [DIM_W-1:0] out_row,
    output logic [DIM_W-1:0] out_col,
    output logic             busy,
    output logic             done
);
    localparam int LB = $clog2(LANES);
    localparam int LW = $clog2(CORES);
    localparam int EW = DIM_W + LB + 1;

    gstate_t           state, state_nx;
    gmode_t            mode_q;
    logic [DIM_W-1:0]  m_q, k_q, n_q;
    logic [DIM_W-1:0]  tm, tn, kq;
    logic [LW-1:0]     lane;

    logic [CORES-1:0]                     lane_ok, lane_ok_nxt;
    logic [LANES-1:0]                     k_mask;
    logic [CORES-1:0][DIM_W-1:0]          a_rd_row, b_rd_row;
    logic [CORES-1:0][LANES-1:0][7:0]     a_vec, b_vec;
    logic [CORES-1:0][31:0]               acc;
    logic                                 kq_last, tile_last, row_end, col_end;
    logic                                 core_clr, emit_fire, emit_end;

    // Lane validity, operand routing by mode, reduction masking.
    always_comb begin
        for (int c = 0; c < CORES; c++) begin
            if (mode_q == MODE_IB) begin
                lane_ok[c]  = ({1'b0, tn} + (DIM_W+1)'(c)) < {1'b0, n_q};
                a_rd_row[c] = tm;
                b_rd_row[c] = tn + DIM_W'(c);
            end else begin
                lane_ok[c]  = ({1'b0, tm} + (DIM_W+1)'(c)) < {1'b0, m_q};
                a_rd_row[c] = tm + DIM_W'(c);
                b_rd_row[c] = tn;
            end
        end
        for (int l = 0; l < LANES; l++) begin
            k_mask[l] = (EW'({kq, LB'(0)}) + EW'(l)) < EW'(k_q);
        end
        lane_ok_nxt = lane_ok >> 1;
        kq_last     = (EW'({kq, LB'(0)}) + EW'(LANES)) >= EW'(k_q);
        row_end     = ({1'b0, tn} + (DIM_W+1)'(CORES)) >= {1'b0, n_q};
        col_end     = (tn == n_q - 1'b1);
        tile_last   = (mode_q == MODE_IB) ? (row_end && tm == m_q - 1'b1)
                                          : (col_end && ({1'b0, tm} + (DIM_W+1)'(CORES)) >= {1'b0, m_q});
    end

    gemm_opbuf #(.ROWS(MAX_M), .DEPTH(MAX_K), .LANES(LANES), .PORTS(CORES), .DIM_W(DIM_W)) u_abuf (
        .clk(clk), .wr_en(a_we), .wr_row(a_row), .wr_k(a_k), .wr_data(a_wdata),
        .rd_row(a_rd_row), .rd_kq(kq), .rd_vec(a_vec)
    );

    gemm_opbuf #(.ROWS(MAX_N), .DEPTH(MAX_K), .LANES(LANES), .PORTS(CORES), .DIM_W(DIM_W)) u_bbuf (
        .clk(clk), .wr_en(b_we), .wr_row(b_col), .wr_k(b_k), .wr_data(b_wdata),
        .rd_row(b_rd_row), .rd_kq(kq), .rd_vec(b_vec)
    );

    assign core_clr = (state == ST_STEP) || (state == ST_IDLE && cfg_start);

    for (genvar c = 0; c < CORES; c++) begin : g_core
        gemm_vcore #(.LANES(LANES)) u_core (
            .clk(clk), .rst_n(rst_n), .clr(core_clr),
            .en((state == ST_MAC) && lane_ok[c]),
            .a_vec(a_vec[c]), .b_vec(b_vec[c]), .k_mask(k_mask),
            .acc(acc[c])
        );
    end

    assign emit_fire = (state == ST_EMIT) && out_ready;
    assign emit_end  = (lane == LW'(CORES - 1)) || !lane_ok_nxt[lane];

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cfg_start) state_nx = ST_MAC;
            ST_MAC:  if (kq_last) state_nx = ST_EMIT;
            ST_EMIT: if (emit_fire && emit_end) state_nx = ST_STEP;
            ST_STEP: state_nx = tile_last ? ST_IDLE : ST_MAC;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Scheduler counters and captured layer configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IB;
            m_q <= '0; k_q <= '0; n_q <= '0;
            tm <= '0; tn <= '0; kq <= '0; lane <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cfg_start) begin
                    mode_q <= gmode_t'(cfg_mode);
                    m_q <= cfg_m; k_q <= cfg_k; n_q <= cfg_n;
                    tm <= '0; tn <= '0; kq <= '0;
                end
                ST_MAC: begin
                    if (kq_last) lane <= '0;
                    else         kq   <= kq + 1'b1;
                end
                ST_EMIT: if (emit_fire && !emit_end) lane <= lane + 1'b1;
                ST_STEP: begin
                    kq <= '0;
                    if (mode_q == MODE_IB) begin
                        if (row_end) begin tn <= '0; tm <= tm + 1'b1; end
                        else         tn <= tn + DIM_W'(CORES);
                    end else begin
                        if (col_end) begin tn <= '0; tm <= tm + DIM_W'(CORES); end
                        else         tn <= tn + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        out_valid = (state == ST_EMIT);
        out_data  = acc[lane];
        out_row   = (mode_q == MODE_IB) ? tm : tm + DIM_W'(lane);
        out_col   = (mode_q == MODE_IB) ? tn + DIM_W'(lane) : tn;
        busy      = (state != ST_IDLE);
        done      = (state == ST_STEP) && tile_last;
    end
endmodule

// File: rtl/gemm_engine_chk.sv
`timescale 1ns/1ps
module gemm_engine_chk #(
    parameter int DIM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mode_bit,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic [DIM_W-1:0] out_row,
    input logic [DIM_W-1:0] out_col,
    input logic [DIM_W-1:0] m_lim,
    input logic [DIM_W-1:0] n_lim
);
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_bit));

    p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row < m_lim) && (out_col < n_lim));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_row) && $stable(out_col));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);
endmodule

bind gemm_engine gemm_engine_chk #(.DIM_W(DIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_bit(mode_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_row(out_row), .out_col(out_col), .m_lim(m_q), .n_lim(n_q)
);

// File: tb/tb_gemm_engine.sv
`timescale 1ns/1ps
module tb_gemm_engine;
    localparam int DW = 12;
    localparam int MM = 12;
    localparam int MK = 16;
    localparam int MN = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0, cfg_mode = 1'b0;
    logic [DW-1:0] cfg_m = '0, cfg_k = '0, cfg_n = '0;
    logic a_we = 1'b0, b_we = 1'b0;
    logic [DW-1:0] a_row = '0, a_k = '0, b_col = '0, b_k = '0;
    logic [7:0] a_wdata = '0, b_wdata = '0;
    logic out_valid, out_ready = 1'b0, busy, done;
    logic [31:0] out_data;
    logic [DW-1:0] out_row, out_col;

    always #2.5 clk = ~clk;

    gemm_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
        .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_n(cfg_n),
        .a_we(a_we), .a_row(a_row), .a_k(a_k), .a_wdata(a_wdata),
        .b_we(b_we), .b_col(b_col), .b_k(b_k), .b_wdata(b_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_row(out_row), .out_col(out_col), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic signed [7:0] a_ref [MM][MK];
    logic signed [7:0] b_ref [MN][MK];
    int exp_row [MM*MN];
    int exp_col [MM*MN];
    int exp_val [MM*MN];
    int n_exp;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // pat 0: random, 1: all -128 x -128, 2: -128 x 127
    task automatic load_operands(input int pat);
        for (int r = 0; r < MM; r++) begin
            for (int kk = 0; kk < MK; kk++) begin
                logic signed [7:0] av, bv;
                case (pat)
                    1: begin av = -8'sd128; bv = -8'sd128; end
                    2: begin av = -8'sd128; bv = 8'sd127; end
                    default: begin av = 8'($urandom); bv = 8'($urandom); end
                endcase
                a_ref[r][kk] = av;
                b_ref[r][kk] = bv;
                @(negedge clk);
                a_we = 1'b1; a_row = DW'(r); a_k = DW'(kk); a_wdata = av;
                b_we = 1'b1; b_col = DW'(r); b_k = DW'(kk); b_wdata = bv;
            end
        end
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    function automatic void build_expected(input bit mode, input int m, input int k, input int n);
        n_exp = 0;
        if (!mode) begin
            for (int r = 0; r < m; r++)
                for (int c0 = 0; c0 < n; c0 += 3)
                    for (int l = 0; l < 3; l++)
                        if (c0 + l < n) begin
                            exp_row[n_exp] = r; exp_col[n_exp] = c0 + l; n_exp++;
                        end
        end else begin
            for (int r0 = 0; r0 < m; r0 += 3)
                for (int c = 0; c < n; c++)
                    for (int l = 0; l < 3; l++)
                        if (r0 + l < m) begin
                            exp_row[n_exp] = r0 + l; exp_col[n_exp] = c; n_exp++;
                        end
        end
        for (int i = 0; i < n_exp; i++) begin
            int s = 0;
            for (int kk = 0; kk < k; kk++)
                s += int'(a_ref[exp_row[i]][kk]) * int'(b_ref[exp_col[i]][kk]);
            exp_val[i] = s;
        end
    endfunction

    task automatic run_layer(input string tag, input bit mode, input int m, input int k,
                             input int n, input int ready_pct, input bit scramble);
        int got = 0;
        int cyc = 0;
        int first_cyc = -1;
        bit seen_done = 0;
        string ordreq = mode ? "R5" : "R4";
        build_expected(mode, m, k, n);
        @(negedge clk);
        cfg_mode = mode; cfg_m = DW'(m); cfg_k = DW'(k); cfg_n = DW'(n);
        cfg_start = 1'b1;
        while (!seen_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            cfg_start = 1'b0;
            if (scramble) begin
                // R2: cfg inputs and start pulses while busy must be ignored
                cfg_mode = ~mode;
                cfg_m = DW'($urandom_range(1, MM));
                cfg_k = DW'($urandom_range(1, MK));
                cfg_n = DW'($urandom_range(1, MN));
                cfg_start = (cyc % 5 == 2);
            end
            if (done) begin
                seen_done = 1;
                cfg_start = 1'b0;
                // R10: done comes right after the last accepted result
                check(got == n_exp, "R10", {tag, " done after last result"}, got, n_exp);
            end
            out_ready = ($urandom_range(0, 99) < ready_pct);
            if (out_valid && first_cyc < 0) first_cyc = cyc;
            if (out_valid && out_ready) begin
                if (got < n_exp) begin
                    check(int'(out_row) == exp_row[got] && int'(out_col) == exp_col[got],
                          ordreq, {tag, " element position (row*1000+col)"},
                          int'(out_row) * 1000 + int'(out_col), exp_row[got] * 1000 + exp_col[got]);
                    check($signed(out_data) == exp_val[got], "R3 R6 R2",
                          {tag, " element value"}, $signed(out_data), exp_val[got]);
                end
                got++;
            end
        end
        out_ready = 1'b0;
        cfg_start = 1'b0;
        check(seen_done, "R10", {tag, " done seen"}, seen_done, 1);
        check(got == m * n, "R7", {tag, " result count"}, got, m * n);
        check(first_cyc == (k + 3) / 4 + 1, "R8", {tag, " first result latency"},
              first_cyc, (k + 3) / 4 + 1);
        @(negedge clk);
        check(!busy && !done, "R10", {tag, " idle after done (busy,done)"},
              {busy, done}, 0);
    endtask

    task automatic t_reset();
        check(!out_valid && !busy && !done, "R1", "reset outputs (valid,busy,done)",
              {out_valid, busy, done}, 0);
    endtask

    task automatic t_ragged_input_bcast();
        load_operands(0);
        run_layer("ib 5x7x4", 1'b0, 5, 7, 4, 100, 1'b0);
    endtask

    task automatic t_ragged_weight_bcast();
        load_operands(0);
        run_layer("wb 5x7x4 bp", 1'b1, 5, 7, 4, 60, 1'b0);
    endtask

    task automatic t_full_size();
        load_operands(0);
        run_layer("ib 12x16x12", 1'b0, 12, 16, 12, 50, 1'b0);
        run_layer("wb 12x16x12", 1'b1, 12, 16, 12, 50, 1'b0);
        run_layer("wb 7x5x11 K ragged", 1'b1, 7, 5, 11, 70, 1'b0);
    endtask

    task automatic t_extremes();
        load_operands(1);
        run_layer("min*min", 1'b0, 3, 16, 3, 80, 1'b0);
        load_operands(2);
        run_layer("min*max", 1'b1, 4, 16, 2, 80, 1'b0);
    endtask

    task automatic t_tiny();
        load_operands(0);
        run_layer("ib 1x1x1", 1'b0, 1, 1, 1, 100, 1'b0);
        run_layer("wb 1x1x1", 1'b1, 1, 1, 1, 30, 1'b0);
    endtask

    task automatic t_cfg_ignored();
        load_operands(0);
        run_layer("ib scrambled cfg", 1'b0, 4, 9, 5, 70, 1'b1);
        run_layer("wb scrambled cfg", 1'b1, 8, 13, 3, 70, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ragged_input_bcast();
        t_ragged_weight_bcast();
        t_full_size();
        t_extremes();
        t_tiny();
        t_cfg_ignored();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule